// File: doc/BRIEF.md
# Calendar Alarm Comparator

This unit sits next to a BCD time-of-day and calendar counter. It holds one alarm target for each of six time fields: seconds, minutes, hours, weekday, day of month and month. Each target carries its own compare-enable bit, so software can arm any combination of fields. A field left disarmed acts as a wildcard.

When the counter signals that seconds have advanced, the unit compares every armed target with the live counter value. If all armed fields agree and at least one field is armed, it sets a sticky alarm flag. An interrupt line is raised while the flag is set and the alarm interrupt is enabled. The year is not part of the comparison.

Software reaches the targets, the flag and the interrupt enable through a simple byte-wide register port. Writes are synchronous and reads are combinational. To arm a new alarm without a stale interrupt, software first disables the interrupt, then clears the flag, loads the targets and finally re-enables the interrupt.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After a synchronous active-low reset, all six alarm registers read 0x00, the control register reads 0x00 and `alarm_irq` is 0.
- R2: The alarm registers sit at addresses 8 to 13 in the order seconds, minutes, hours, weekday, day of month, month. Each reads back the full byte last written to it.
- R3: In an alarm register, bit 7 arms the field and bits 6:0 hold the BCD target. A disarmed field takes no part in the match, whatever the counter holds.
- R4: On a clock edge with `sec_tick` = 1, the flag is set when every armed field equals its counter field and at least one field is armed. The flag reads 1 from the next cycle. Counter field i occupies `cnt_bcd[7*i+6 : 7*i]`, with field 0 = seconds and field 5 = month.
- R5: With no field armed, a tick never sets the flag.
- R6: Counters that match the targets set nothing on edges where `sec_tick` = 0.
- R7: Once set, the flag stays 1 through later ticks that do not match, until software clears it.
- R8: The control register at address 14 holds the flag in bit 0 and the interrupt enable in bit 3. Writing 0 to bit 0 clears the flag and writing 1 to bit 0 leaves it unchanged. Bit 3 takes the written value. The other bits read 0.
- R9: A write that clears the flag on the same edge as a matching tick leaves the flag at 1.
- R10: `alarm_irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R11: Addresses other than 8 to 14 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Combinational read data |
| sec_tick | input | 1 | One-cycle pulse: counters have just advanced a second |
| cnt_bcd | input | 42 | Live counter fields, 7 bits each, seconds in the low bits |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench builds the unit with its default parameters: 8-bit fields, six fields and a 4-bit address. This covers the whole map, from the unused low addresses through the six targets to the control byte at 14. Random traffic mixes target writes, control writes and ticks whose counters are often copied from the armed targets, so that matches, near misses and wildcard fields all occur. Directed sequences cover the no-field-armed tick, matches without a tick, the clear that coincides with a match, and the interrupt gating.

// File: rtl/rtca_pkg.sv
// Shared constants for the alarm comparator: register indices and
// control-bit positions. Assumes an address space of at least 16 entries.
package rtca_pkg;
    localparam int unsigned ALM_BASE = 8;   // first alarm register (seconds)
    localparam int unsigned CTRL_IDX = 14;  // control register index
    localparam int unsigned FLAG_BIT = 0;   // sticky alarm flag
    localparam int unsigned AIE_BIT  = 3;   // alarm interrupt enable
endpackage

// File: rtl/rtca_field.sv
// One alarm target register with its compare-enable bit in the MSB.
// Reports whether it is armed and whether it agrees with its counter field.
// Assumes the counter field is FIELD_W-1 bits wide (BCD, no top bit).
module rtca_field #(
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned MY_ADDR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic [FIELD_W-2:0] cnt,
    output logic [FIELD_W-1:0] value_q,
    output logic               armed,
    output logic               agree
);
    localparam int unsigned VAL_W = FIELD_W - 1;

    logic sel;
    assign sel = wr_en && (wr_addr == ADDR_W'(MY_ADDR));

    // Target storage: loaded by a write to this field's address.
    always_ff @(posedge clk) begin
        if (!rst_n)   value_q <= '0;
        else if (sel) value_q <= wr_data;
    end

    // Field status: armed bit and value equality against the counter.
    assign armed = value_q[FIELD_W-1];
    assign agree = (value_q[VAL_W-1:0] == cnt);

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(value_q)); // R2
endmodule

// File: rtl/rtca_combine.sv
// Reduces per-field results into one match: every armed field agrees and
// at least one field is armed. Pure combinational logic.
module rtca_combine #(
    parameter int unsigned NUM_FIELDS = 6
) (
    input  logic [NUM_FIELDS-1:0] armed,
    input  logic [NUM_FIELDS-1:0] agree,
    output logic                  match
);
    logic [NUM_FIELDS-1:0] pass;

    // A disarmed field is a wildcard and always passes.
    genvar g;
    generate
        for (g = 0; g < NUM_FIELDS; g++) begin : g_pass
            assign pass[g] = !armed[g] || agree[g];
        end
    endgenerate

    // Overall match needs all passes plus one armed field.
    assign match = (&pass) && (|armed);
endmodule

// File: rtl/rtca_ctrl.sv
// Control byte: sticky alarm flag and interrupt enable, plus the interrupt
// output. A matching tick wins over a coincident clear of the flag.
module rtca_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_flag,
    input  logic wr_aie,
    input  logic sec_tick,
    input  logic match,
    output logic flag_q,
    output logic aie_q,
    output logic alarm_irq
);
    logic clr_req;
    assign clr_req = ctrl_wr && !wr_flag;

    // Sticky flag: set by a matching tick, cleared only by a 0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (sec_tick && match) flag_q <= 1'b1;
        else if (clr_req)           flag_q <= 1'b0;
    end

    // Interrupt enable: follows the written control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       aie_q <= 1'b0;
        else if (ctrl_wr) aie_q <= wr_aie;
    end

    // Interrupt request gated by the enable.
    assign alarm_irq = flag_q && aie_q;

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && match) |=> flag_q); // R9
    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(sec_tick)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> ($past(sec_tick) || $past(ctrl_wr))); // R10
endmodule

// File: rtl/rtc_alarm_unit.sv
// Alarm comparator beside a BCD calendar. Holds one armed/target register
// per time field, compares on each seconds tick, keeps a sticky flag and
// drives an interrupt. Assumes ADDR_W can reach the control index.
module rtc_alarm_unit #(
    parameter int unsigned FIELD_W    = 8,
    parameter int unsigned NUM_FIELDS = 6,
    parameter int unsigned ADDR_W     = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [FIELD_W-1:0]                  wr_data,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [FIELD_W-1:0]                  rd_data,
    input  logic                                sec_tick,
    input  logic [NUM_FIELDS*(FIELD_W-1)-1:0]   cnt_bcd,
    output logic                                alarm_irq
);
    import rtca_pkg::*;

    localparam int unsigned VAL_W = FIELD_W - 1;

    logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_q;
    logic [NUM_FIELDS-1:0]              armed;
    logic [NUM_FIELDS-1:0]              agree;
    logic                               match;
    logic                               flag_q;
    logic                               aie_q;
    logic                               ctrl_wr;

    // One register and comparator per time field.
    genvar g;
    generate
        for (g = 0; g < NUM_FIELDS; g++) begin : g_field
            rtca_field #(
                .FIELD_W (FIELD_W),
                .ADDR_W  (ADDR_W),
                .MY_ADDR (ALM_BASE + g)
            ) u_field (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .cnt     (cnt_bcd[g*VAL_W +: VAL_W]),
                .value_q (field_q[g]),
                .armed   (armed[g]),
                .agree   (agree[g])
            );
        end
    endgenerate

    rtca_combine #(.NUM_FIELDS(NUM_FIELDS)) u_combine (
        .armed (armed),
        .agree (agree),
        .match (match)
    );

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_IDX));

    rtca_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wr_flag   (wr_data[FLAG_BIT]),
        .wr_aie    (wr_data[AIE_BIT]),
        .sec_tick  (sec_tick),
        .match     (match),
        .flag_q    (flag_q),
        .aie_q     (aie_q),
        .alarm_irq (alarm_irq)
    );

    // Read mux: alarm targets, control byte, zero elsewhere.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (rd_addr == ADDR_W'(ALM_BASE + i)) rd_data = field_q[i];
        end
        if (rd_addr == ADDR_W'(CTRL_IDX)) begin
            rd_data[FLAG_BIT] = flag_q;
            rd_data[AIE_BIT]  = aie_q;
        end
    end

    AST_NO_ARM_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed == '0) |-> !match); // R5
    AST_DISARMED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (&(agree | ~armed)) && (|armed)) |=> flag_q); // R3
endmodule

// File: tb/sim_rtc_alarm_unit.sv
`timescale 1ns/1ps
module sim_rtc_alarm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        sec_tick = 1'b0;
    logic [41:0] cnt_bcd = '0;
    logic        alarm_irq;

    int vectors = 0;
    int fails = 0;

    logic [7:0] m_alm [6];
    logic       m_flag;
    logic       m_aie;

    always #2.5 clk = ~clk;

    rtc_alarm_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sec_tick(sec_tick), .cnt_bcd(cnt_bcd), .alarm_irq(alarm_irq)
    );

    function automatic bit m_match(logic [41:0] c);
        bit any = 0;
        bit ok = 1;
        for (int i = 0; i < 6; i++) begin
            if (m_alm[i][7]) begin
                any = 1;
                if (m_alm[i][6:0] != c[i*7 +: 7]) ok = 0;
            end
        end
        return any && ok;
    endfunction

    function automatic logic [41:0] cnt_of_targets();
        logic [41:0] c;
        for (int i = 0; i < 6; i++) c[i*7 +: 7] = m_alm[i][6:0];
        return c;
    endfunction

    function automatic logic [7:0] m_ctrl();
        return {4'b0, m_aie, 2'b0, m_flag};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock with the given stimulus; model updated, control and irq checked.
    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic tk, input logic [41:0] c, input string tag);
        bit mt;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; sec_tick = tk; cnt_bcd = c; rd_addr = 4'd14;
        @(posedge clk);
        mt = m_match(c);
        if (we && a == 4'd14 && !d[0]) m_flag = 1'b0;
        if (tk && mt) m_flag = 1'b1;
        if (we && a == 4'd14) m_aie = d[3];
        if (we && a >= 4'd8 && a <= 4'd13) m_alm[a-8] = d;
        #1;
        check({tag, " ctrl"}, rd_data, m_ctrl());
        check("R10 irq", {7'b0, alarm_irq}, {7'b0, m_flag & m_aie});
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0; rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, cnt_bcd, tag);
    endtask

    initial begin
        logic [41:0] c;
        void'($urandom(32'd1234));
        for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
        m_flag = 1'b0; m_aie = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        for (int a = 8; a <= 14; a++) rd_check(4'(a), 8'h00, "R1 reset");
        check("R1 irq", {7'b0, alarm_irq}, 8'h00);

        // R2 map and readback
        for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'(8'h11 * (i + 1)), "R2 wr");
        for (int i = 0; i < 6; i++) rd_check(4'(8 + i), 8'(8'h11 * (i + 1)), "R2 readback");

        // R11 unmapped address: reads zero, write changes nothing
        wr(4'd3, 8'hFF, "R11 wr");
        wr(4'd15, 8'h09, "R11 wr");
        rd_check(4'd3, 8'h00, "R11 read");
        rd_check(4'd15, 8'h00, "R11 read");
        for (int i = 0; i < 6; i++) rd_check(4'(8 + i), m_alm[i], "R11 no change");
        rd_check(4'd14, m_ctrl(), "R11 ctrl");

        // R5 nothing armed: tick with equal counters sets nothing
        for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'h00, "R5 disarm");
        step(1'b0, 4'd0, 8'h00, 1'b1, 42'd0, "R5 tick");
        rd_check(4'd14, 8'h00, "R5 no flag");

        // R3 only minutes armed (0x30): other fields are wildcards
        wr(4'd9, 8'hB0, "R3 arm min");
        wr(4'd10, 8'h23, "R3 hour disarmed");
        c = {$urandom, $urandom}; c[7 +: 7] = 7'h31;
        step(1'b0, 4'd0, 8'h00, 1'b1, c, "R3 miss");
        rd_check(4'd14, 8'h00, "R3 armed mismatch");
        c[7 +: 7] = 7'h30;
        // R6 matching counters without a tick
        repeat (3) step(1'b0, 4'd0, 8'h00, 1'b0, c, "R6 no tick");
        rd_check(4'd14, 8'h00, "R6 no flag");
        step(1'b0, 4'd0, 8'h00, 1'b1, c, "R4 R3 hit");
        rd_check(4'd14, 8'h01, "R4 flag set");

        // R7 sticky through non-matching ticks
        c[7 +: 7] = 7'h45;
        step(1'b0, 4'd0, 8'h00, 1'b1, c, "R7 tick");
        rd_check(4'd14, 8'h01, "R7 sticky");

        // R8 writing 1 to flag keeps it; aie follows; writing 0 clears
        wr(4'd14, 8'h09, "R8 aie on");
        check("R10 irq on", {7'b0, alarm_irq}, 8'h01);
        wr(4'd14, 8'hF6, "R8 clear");
        rd_check(4'd14, 8'h00, "R8 cleared, spare bits 0");
        wr(4'd14, 8'h01, "R8 write1 no set");
        rd_check(4'd14, 8'h00, "R8 flag stays 0");

        // R9 clear coinciding with a matching tick
        c[7 +: 7] = 7'h30;
        step(1'b0, 4'd0, 8'h00, 1'b1, c, "R9 set");
        step(1'b1, 4'd14, 8'h08, 1'b1, c, "R9 clear+match");
        rd_check(4'd14, 8'h09, "R9 flag kept");
        check("R10 irq", {7'b0, alarm_irq}, 8'h01);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned r = $urandom % 10;
            c = cnt_of_targets();
            if ($urandom % 3 == 0) c[($urandom % 6) * 7 +: 7] = 7'($urandom);
            if (r < 3)
                step(1'b1, 4'(8 + $urandom % 6),
                     {($urandom % 3 != 0) ? 1'b1 : 1'b0, 7'($urandom % 60)}, 1'b0, c, "R2 rnd");
            else if (r < 5)
                step(1'b1, 4'd14, 8'($urandom), ($urandom % 2) == 1, c, "R8 rnd");
            else if (r < 6)
                step(1'b1, 4'($urandom % 8), 8'($urandom), 1'b0, c, "R11 rnd");
            else
                step(1'b0, 4'd0, 8'h00, ($urandom % 4) != 0, c, "R4 rnd");
        end
        for (int i = 0; i < 6; i++) rd_check(4'(8 + i), m_alm[i], "R2 final");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule